// File: doc/BRIEF.md
# Hash Message Schedule Generator

This block produces the eighty 32-bit schedule words used by the SHA-1 compression rounds. A 512-bit message block is captured on an init strobe. After that, the round engine presents a round index, and the block returns the schedule word for that round on the same cycle through combinational logic.

Only sixteen words are ever stored. The first sixteen rounds read the captured block words directly. Each later round computes its word from four entries of a sixteen-slot circular window. It returns that word and writes it into the slot named by the low four bits of the round index on the next clock edge. Because the window is overwritten as it goes, the round index must step by exactly one per cycle after the load for the expanded words to be correct.

Top module: `sched_gen`

## Requirements
- R1: A synchronous active-high reset clears all sixteen window slots to zero. It takes priority over init. After reset, round indices 0 to 15 return zero.
- R2: When init is high at a clock edge, slot j is loaded with block bits [511-32j : 480-32j]. Slot 0 therefore holds the most significant word.
- R3: For round indices 0 to 15, the output is the window slot selected by index bits 3:0. No slot is written, so holding such an index leaves the output unchanged.
- R4: For round indices 16 to 79, the output is rotl1(s[(i-3)&15] ^ s[(i-8)&15] ^ s[(i-14)&15] ^ s[i&15]). At the next edge this value is written into slot i&15.
- R5: After a load, stepping the index 0,1,...,79 one per cycle yields the standard SHA-1 schedule words W0..W79 of the loaded block.
- R6: If init is high while the index is in 16..79, the load wins and the expansion write-back is suppressed.
- R7: Round indices 80 to 127 give an output of zero and write nothing.
- R8: After a complete 0..79 pass, slot j holds W(64+j), which is visible by reading index j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Load strobe for the message block |
| blk | input | 512 | Message block, word 0 in the top bits |
| round_idx | input | 7 | Round index whose schedule word is wanted |
| w_out | output | 32 | Schedule word for round_idx |

## Verification
The load and the in-place expansion write can land on the same edge when init is raised while the index sits in the expansion range. The bench provokes this by holding the index at 20 during a second load over a previously filled window. It then reads every slot through indices 0 to 15 and expects exactly the new block's words, so any stray write-back into slot 4 shows up as a mismatch. The full 80-word passes are compared against a model of the recurrence that the bench computes from the full-history form of the schedule, not the windowed form.

// File: rtl/sched_pkg.sv
package sched_pkg;
    parameter int WORD_W   = 32;
    parameter int WINDOW   = 16;
    parameter int ROUNDS   = 80;
    parameter int ADDR_W   = 7;
    localparam int SLOT_W  = $clog2(WINDOW);
    localparam int BLK_W   = WORD_W * WINDOW;
    // Recurrence taps, counted back from the current round
    localparam int TAP_A   = 3;
    localparam int TAP_B   = 8;
    localparam int TAP_C   = 14;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WINDOW-1:0][WORD_W-1:0] window_t;

    typedef enum logic [1:0] {
        PH_DIRECT = 2'd0,
        PH_EXPAND = 2'd1,
        PH_IDLE   = 2'd2
    } phase_t;

    typedef struct packed {
        logic                 en;
        logic [SLOT_W-1:0]    slot;
        word_t                data;
    } wr_req_t;

    function automatic word_t rotl1(input word_t x);
        return {x[WORD_W-2:0], x[WORD_W-1]};
    endfunction

    function automatic word_t block_word(input logic [BLK_W-1:0] b,
                                         input logic [SLOT_W-1:0] j);
        return b[BLK_W-1-WORD_W*int'(j) -: WORD_W];
    endfunction
endpackage

// File: rtl/sched_phase.sv
module sched_phase
    import sched_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int NDIR   = WINDOW,
    parameter int NROUND = ROUNDS
) (
    input  logic [AW-1:0] idx,
    output phase_t        phase
);
    always_comb begin
        if (int'(idx) < NDIR)
            phase = PH_DIRECT;
        else if (int'(idx) < NROUND)
            phase = PH_EXPAND;
        else
            phase = PH_IDLE;
    end
endmodule

// File: rtl/sched_window.sv
module sched_window
    import sched_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int N  = WINDOW,
    localparam int SW = $clog2(N),
    localparam int BW = W * N
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [BW-1:0]         blk,
    input  logic                  wr_en,
    input  logic [SW-1:0]         wr_slot,
    input  logic [W-1:0]          wr_data,
    output logic [N-1:0][W-1:0]   q
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= '0;
            else if (load)
                q[g] <= blk[BW-1-W*g -: W];
            else if (wr_en && (wr_slot == SW'(g)))
                q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/sched_expand.sv
module sched_expand
    import sched_pkg::*;
(
    input  window_t           win,
    input  logic [SLOT_W-1:0] cur,
    output word_t             w_new
);
    logic [SLOT_W-1:0] ia, ib, ic;
    word_t             mix;

    always_comb begin
        ia    = cur - SLOT_W'(TAP_A);
        ib    = cur - SLOT_W'(TAP_B);
        ic    = cur - SLOT_W'(TAP_C);
        mix   = win[ia] ^ win[ib] ^ win[ic] ^ win[cur];
        w_new = rotl1(mix);
    end
endmodule

// File: rtl/sched_gen.sv
module sched_gen
    import sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic [BLK_W-1:0]  blk,
    input  logic [ADDR_W-1:0] round_idx,
    output logic [WORD_W-1:0] w_out
);
    phase_t            phase;
    window_t           win;
    word_t             w_exp;
    wr_req_t           wr;
    logic [SLOT_W-1:0] slot;

    assign slot = round_idx[SLOT_W-1:0];

    sched_phase u_phase (
        .idx   (round_idx),
        .phase (phase)
    );

    sched_expand u_exp (
        .win   (win),
        .cur   (slot),
        .w_new (w_exp)
    );

    always_comb begin
        wr.en   = (phase == PH_EXPAND) && !init;
        wr.slot = slot;
        wr.data = w_exp;
    end

    sched_window u_win (
        .clk     (clk),
        .rst     (rst),
        .load    (init),
        .blk     (blk),
        .wr_en   (wr.en),
        .wr_slot (wr.slot),
        .wr_data (wr.data),
        .q       (win)
    );

    always_comb begin
        unique case (phase)
            PH_DIRECT: w_out = win[slot];
            PH_EXPAND: w_out = w_exp;
            default:   w_out = '0;
        endcase
    end
endmodule

// File: rtl/sched_gen_chk.sv
module sched_gen_chk
    import sched_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              init,
    input logic [BLK_W-1:0]  blk,
    input logic [ADDR_W-1:0] round_idx,
    input logic [WORD_W-1:0] w_out
);
    localparam int FIRST_EXP = WINDOW;
    localparam int END_EXP   = ROUNDS;

    // R1: the edge after a reset, direct reads see zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        ($past(rst) && !rst && int'(round_idx) < FIRST_EXP) |-> (w_out == '0));

    // R2: the edge after a load, direct reads see the loaded block word
    assert_load_word_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(init) && !$past(rst) && int'(round_idx) < FIRST_EXP)
        |-> (w_out == block_word($past(blk), round_idx[SLOT_W-1:0])));

    // R3: holding a direct index without a load leaves the output unchanged
    assert_direct_stable_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(init) && int'(round_idx) < FIRST_EXP
         && round_idx == $past(round_idx)) |-> (w_out == $past(w_out)));

    // R4: an expanded word lands in slot i&15
    assert_writeback_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(init)
         && int'($past(round_idx)) >= FIRST_EXP && int'($past(round_idx)) < END_EXP
         && round_idx == ADDR_W'($past(round_idx[SLOT_W-1:0])))
        |-> (w_out == $past(w_out)));

    // R6: a load during an expansion index wins over the write-back
    assert_init_priority_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(init) && !$past(rst) && int'($past(round_idx)) >= FIRST_EXP
         && round_idx == ADDR_W'($past(round_idx[SLOT_W-1:0])))
        |-> (w_out == block_word($past(blk), round_idx[SLOT_W-1:0])));

    // R7: indices past the last round read zero
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(round_idx) >= END_EXP) |-> (w_out == '0));
endmodule

bind sched_gen sched_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .init      (init),
    .blk       (blk),
    .round_idx (round_idx),
    .w_out     (w_out)
);

// File: tb/sim_sched_gen.sv
module sim_sched_gen;
    import sched_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              init = 1'b0;
    logic [BLK_W-1:0]  blk = '0;
    logic [ADDR_W-1:0] round_idx = '0;
    logic [WORD_W-1:0] w_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] ref_w [80];

    always #4 clk = ~clk;   // 125 MHz

    sched_gen u0 (
        .clk       (clk),
        .rst       (rst),
        .init      (init),
        .blk       (blk),
        .round_idx (round_idx),
        .w_out     (w_out)
    );

    task automatic check(input string req, input int idx,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s idx %0d: got %h expected %h", req, idx, got, exp);
        end
    endtask

    // Full-history form of the schedule, independent of the windowed form
    task automatic build_model(input logic [511:0] b);
        for (int t = 0; t < 80; t++) begin
            if (t < 16) ref_w[t] = b[511-32*t -: 32];
            else begin
                logic [31:0] x;
                x = ref_w[t-3] ^ ref_w[t-8] ^ ref_w[t-14] ^ ref_w[t-16];
                ref_w[t] = {x[30:0], x[31]};
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int j = 0; j < 16; j++) begin
            round_idx = 7'(j);
            @(negedge clk);
            check("R1", j, w_out, 32'h0);
            @(posedge clk); #1;
        end
    endtask

    // Ends at posedge+1 with the window loaded
    task automatic t_load(input logic [511:0] b, input int idx_during);
        @(posedge clk); #1;
        blk = b; init = 1'b1; round_idx = 7'(idx_during);
        @(posedge clk); #1;
        init = 1'b0;
    endtask

    task automatic t_full_pass(input logic [511:0] b);
        build_model(b);
        t_load(b, 0);
        for (int i = 0; i < 80; i++) begin
            round_idx = 7'(i);
            @(negedge clk);
            // R5: each word of the pass matches the model
            if (i < 16) check("R2", i, w_out, ref_w[i]);
            else        check("R4", i, w_out, ref_w[i]);
            @(posedge clk); #1;
        end
    endtask

    task automatic t_idle_and_residue();
        for (int k = 0; k < 3; k++) begin
            round_idx = (k == 0) ? 7'd80 : (k == 1) ? 7'd100 : 7'd127;
            @(negedge clk);
            check("R7", int'(round_idx), w_out, 32'h0);
            @(posedge clk); #1;
        end
        for (int j = 0; j < 16; j++) begin
            round_idx = 7'(j);
            @(negedge clk);
            check("R8", j, w_out, ref_w[64+j]);
            @(posedge clk); #1;
        end
    endtask

    task automatic t_hold_direct();
        logic [31:0] first;
        round_idx = 7'd5;
        @(negedge clk);
        first = w_out;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            @(negedge clk);
            check("R3", 5, w_out, first);
        end
        @(posedge clk); #1;
    endtask

    task automatic t_init_collision(input logic [511:0] a, input logic [511:0] b);
        t_load(a, 0);
        t_load(b, 20);
        for (int j = 0; j < 16; j++) begin
            round_idx = 7'(j);
            @(negedge clk);
            check("R6", j, w_out, b[511-32*j -: 32]);
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [511:0] abc;
        logic [511:0] pat;
        abc = {32'h61626380, {14{32'h0}}, 32'h00000018};
        for (int j = 0; j < 16; j++)
            pat[511-32*j -: 32] = (32'h9e3779b9 * 32'(j+1)) ^ 32'h5a5a0f0f;

        t_reset();
        t_full_pass(abc);
        t_idle_and_residue();
        t_hold_direct();
        t_full_pass(pat);
        t_init_collision(abc, pat);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule